// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag and Request Unit

This block gathers three interrupt causes of a real-time clock (alarm match, periodic tick and end of a time update) into a status byte, and raises an interrupt request to the host whenever a recorded cause is also enabled. The timekeeping logic reports each cause as a single-cycle pulse. The matching flag is recorded whether or not that cause is enabled. The host can therefore poll the status byte with all interrupts masked.

The host writes the three enable bits through a write strobe and reads the status byte by holding a read strobe high for the read cycle. The returned byte is frozen for the whole read. When the read ends, only the flags that were returned as set are cleared. Any cause that fires while the read is in progress is parked, then posted to its flag in the cycle after the read ends, so no event is lost. The request is available as a fixed active-low line and as a second copy whose polarity is chosen by a configuration input.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: An event pulse sets its flag one clock later whatever its enable bit holds. In the status byte, bit 6 is the periodic flag, bit 5 the alarm flag and bit 4 the update-ended flag, and bits 3:0 always read 0.
- R2: `irq_n_o` is 0 exactly while at least one source has both its flag and its enable bit at 1, and is 1 otherwise.
- R3: A write with `en_we_i` high loads `en_wdata_i` (bit 2 periodic, bit 1 alarm, bit 0 update-ended) at that clock edge. If the flag is already set, `irq_n_o` goes low right after that edge.
- R4: Bit 7 of `rd_data_o` is a summary bit. It is 1 exactly when the request was active at the capture edge, which is the last edge at which `rd_i` was low.
- R5: While `rd_i` is high, `rd_data_o` does not change.
- R6: At the first clock edge with `rd_i` low after a read, every flag returned as 1 is cleared. Flags returned as 0 are kept.
- R7: An event that arrives while `rd_i` is high leaves the flags and the request unchanged during the read. It sets its flag at the edge that ends the read, and this holds even when the read clears that same flag.
- R8: `irq_ext_o` equals `irq_n_o` when `irq_pol_i` is 0, and equals its inverse (active high) when `irq_pol_i` is 1.
- R9: After reset, all flags, enables and parked events are 0, `rd_data_o` is 0x00 and `irq_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_alarm_i | input | 1 | Alarm match event pulse |
| evt_periodic_i | input | 1 | Periodic tick event pulse |
| evt_update_i | input | 1 | Update-ended event pulse |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 3 | Enable bits: 2 periodic, 1 alarm, 0 update-ended |
| rd_i | input | 1 | Status read strobe, held high for the read cycle |
| irq_pol_i | input | 1 | External request polarity: 0 active low, 1 active high |
| rd_data_o | output | 8 | Status byte: summary, three flags, four zero bits |
| irq_n_o | output | 1 | Interrupt request, active low |
| irq_ext_o | output | 1 | Interrupt request with selectable polarity |

## Verification
The bench sets flags with their enables off to show that flags are recorded independently of the mask. It enables each source alone and then every source except one, which separates a correct per-source gate from a request built on flags only or enables only. Enabling a source after its flag is already set checks that the request responds to the enable write itself. Events injected during a read cover both a cause whose flag is not being cleared and the same cause as the flag that read is clearing, so an event lost in the clear, or posted early into the frozen byte, both show up at the ports.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int NSRC     = 3;
  localparam int DATA_W   = 8;
  localparam int FLAG_LSB = 4;
  localparam int SUM_BIT  = DATA_W - 1;

  // source index order; the status bit of source i is FLAG_LSB + i
  localparam int SRC_UPD = 0;
  localparam int SRC_ALM = 1;
  localparam int SRC_PER = 2;

  function automatic logic any_req(logic [NSRC-1:0] flags, logic [NSRC-1:0] ens);
    return |(flags & ens);
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(logic sum, logic [NSRC-1:0] flags);
    logic [DATA_W-1:0] b;
    b = '0;
    b[SUM_BIT] = sum;
    for (int i = 0; i < NSRC; i++) b[FLAG_LSB+i] = flags[i];
    return b;
  endfunction

  function automatic logic [NSRC-1:0] unpack_flags(logic [DATA_W-1:0] b);
    logic [NSRC-1:0] f;
    for (int i = 0; i < NSRC; i++) f[i] = b[FLAG_LSB+i];
    return f;
  endfunction
endpackage

// File: rtl/rtc_irq_src.sv
module rtc_irq_src (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic rd_hold_i,
  input  logic rd_end_i,
  input  logic rd_clr_i,
  input  logic en_we_i,
  input  logic en_d_i,
  output logic flag_o,
  output logic en_o,
  output logic req_o
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      pend_q <= 1'b0;
      en_o   <= 1'b0;
    end else begin
      if (en_we_i) en_o <= en_d_i;
      if (rd_end_i) begin
        flag_o <= (flag_o & ~rd_clr_i) | pend_q | evt_i;
        pend_q <= 1'b0;
      end else if (rd_hold_i) begin
        pend_q <= pend_q | evt_i;
      end else begin
        flag_o <= flag_o | evt_i;
      end
    end
  end

  assign req_o = flag_o & en_o;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !rd_hold_i) |=> flag_o); // R1
  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    en_we_i |=> (en_o == $past(en_d_i))); // R3
  AST_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hold_i |=> $stable(flag_o)); // R7
  AST_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hold_i && evt_i) |=> pend_q); // R7
  AST_POST_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end_i && pend_q) |=> flag_o); // R7
  AST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end_i && rd_clr_i && !pend_q && !evt_i) |=> !flag_o); // R6
endmodule

// File: rtl/rtc_irq_rdctl.sv
module rtc_irq_rdctl #(
  parameter int DATA_W = rtc_irq_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] live_i,
  output logic              rd_end_o,
  output logic [DATA_W-1:0] snap_o
);
  logic rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      snap_o <= '0;
    end else begin
      rd_q <= rd_i;
      if (!rd_i) snap_o <= live_i;
    end
  end

  assign rd_end_o = rd_q & ~rd_i;

  AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> $stable(snap_o)); // R5
  AST_END_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_end_o |=> !rd_end_o); // R6
endmodule

// File: rtl/rtc_irq_drv.sv
module rtc_irq_drv #(
  parameter int NSRC = rtc_irq_pkg::NSRC
) (
  input  logic [NSRC-1:0] req_i,
  input  logic            pol_i,
  output logic            act_o,
  output logic            irq_n_o,
  output logic            irq_ext_o
);
  always_comb begin
    act_o     = |req_i;
    irq_n_o   = ~act_o;
    irq_ext_o = pol_i ? act_o : ~act_o;
  end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_alarm_i,
  input  logic              evt_periodic_i,
  input  logic              evt_update_i,
  input  logic              en_we_i,
  input  logic [NSRC-1:0]   en_wdata_i,
  input  logic              rd_i,
  input  logic              irq_pol_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_n_o,
  output logic              irq_ext_o
);
  logic [NSRC-1:0]   evt_w;
  logic [NSRC-1:0]   flag_w;
  logic [NSRC-1:0]   en_w;
  logic [NSRC-1:0]   req_w;
  logic [NSRC-1:0]   clr_w;
  logic [DATA_W-1:0] live_w;
  logic              rd_end_w;
  logic              act_w;

  always_comb begin
    evt_w          = '0;
    evt_w[SRC_UPD] = evt_update_i;
    evt_w[SRC_ALM] = evt_alarm_i;
    evt_w[SRC_PER] = evt_periodic_i;
  end

  assign clr_w  = unpack_flags(rd_data_o);
  assign live_w = pack_status(act_w, flag_w);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    rtc_irq_src u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (evt_w[g]),
      .rd_hold_i (rd_i),
      .rd_end_i  (rd_end_w),
      .rd_clr_i  (clr_w[g]),
      .en_we_i   (en_we_i),
      .en_d_i    (en_wdata_i[g]),
      .flag_o    (flag_w[g]),
      .en_o      (en_w[g]),
      .req_o     (req_w[g])
    );
  end

  rtc_irq_rdctl #(.DATA_W(DATA_W)) u_rdctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_i     (rd_i),
    .live_i   (live_w),
    .rd_end_o (rd_end_w),
    .snap_o   (rd_data_o)
  );

  rtc_irq_drv #(.NSRC(NSRC)) u_drv (
    .req_i     (req_w),
    .pol_i     (irq_pol_i),
    .act_o     (act_w),
    .irq_n_o   (irq_n_o),
    .irq_ext_o (irq_ext_o)
  );

  AST_REQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    any_req(flag_w, en_w) |-> !irq_n_o); // R2
  AST_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_w == '0) |-> irq_n_o); // R2
  AST_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_i) |-> (rd_data_o[SUM_BIT] == $past(!irq_n_o))); // R4
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[FLAG_LSB-1:0] == '0); // R1
  AST_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pol_i |-> (irq_ext_o == !irq_n_o)); // R8
endmodule

// File: tb/rtc_irq_ctrl_test.sv
module rtc_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_alarm_i = 1'b0, evt_periodic_i = 1'b0, evt_update_i = 1'b0;
  logic       en_we_i = 1'b0;
  logic [2:0] en_wdata_i = 3'b000;
  logic       rd_i = 1'b0;
  logic       irq_pol_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       irq_n_o, irq_ext_o;

  int n_chk = 0;
  int n_bad = 0;

  rtc_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .evt_alarm_i(evt_alarm_i), .evt_periodic_i(evt_periodic_i), .evt_update_i(evt_update_i),
    .en_we_i(en_we_i), .en_wdata_i(en_wdata_i), .rd_i(rd_i), .irq_pol_i(irq_pol_i),
    .rd_data_o(rd_data_o), .irq_n_o(irq_n_o), .irq_ext_o(irq_ext_o)
  );

  always #4 clk = ~clk;

  // expected status byte, from R1/R4: summary, periodic, alarm, update, zeros
  function automatic logic [7:0] status(input logic sum, input logic per, input logic alm,
                                        input logic upd);
    return {sum, per, alm, upd, 4'b0000};
  endfunction

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic check(input logic ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_byte(input string req, input logic [7:0] exp);
    check(rd_data_o === exp, req, rd_data_o, exp);
  endtask

  task automatic check_irq(input string req, input logic exp);
    check(irq_n_o === exp, req, {7'b0, irq_n_o}, {7'b0, exp});
  endtask

  // pulse events: m[2] periodic, m[1] alarm, m[0] update
  task automatic pulse(input logic [2:0] m);
    evt_periodic_i = m[2]; evt_alarm_i = m[1]; evt_update_i = m[0];
    tick;
    evt_periodic_i = 1'b0; evt_alarm_i = 1'b0; evt_update_i = 1'b0;
  endtask

  task automatic write_en(input logic [2:0] v);
    en_we_i = 1'b1; en_wdata_i = v;
    tick;
    en_we_i = 1'b0;
  endtask

  // full read: holds rd_i for two cycles, returns the byte, lets the clear settle
  task automatic do_read(output logic [7:0] v);
    rd_i = 1'b1;
    v = rd_data_o;
    tick; tick;
    rd_i = 1'b0;
    tick; tick;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    tick;
    check_byte("R9 reset status", 8'h00);
    check_irq("R9 reset request", 1'b1);
    check(irq_ext_o === 1'b1, "R8 ext idle active-low", {7'b0, irq_ext_o}, 8'h01);
    do_read(v);
    check(v === 8'h00, "R9 reset read", v, 8'h00);
  endtask

  task automatic t_flag_masked;
    logic [7:0] v;
    pulse(3'b010);
    check_irq("R2 masked flag no request", 1'b1);
    tick;
    check_byte("R1 alarm flag bit5 with enable off", status(1'b0, 1'b0, 1'b1, 1'b0));
    rd_i = 1'b1;
    tick;
    check_byte("R5 frozen cycle 1", 8'h20);
    tick;
    check_byte("R5 frozen cycle 2", 8'h20);
    rd_i = 1'b0;
    tick; tick;
    check_byte("R6 alarm cleared after read", 8'h00);
    pulse(3'b101);
    tick;
    check_byte("R1 periodic+update bits 6,4", status(1'b0, 1'b1, 1'b0, 1'b1));
    do_read(v);
    check_byte("R6 both cleared", 8'h00);
  endtask

  task automatic t_late_enable;
    logic [7:0] v;
    pulse(3'b100);
    tick;
    check_irq("R2 periodic masked", 1'b1);
    write_en(3'b100);
    check_irq("R3 request right after enable write", 1'b0);
    tick;
    check_byte("R4 summary set with periodic", 8'hC0);
    irq_pol_i = 1'b1; #1;
    check(irq_ext_o === 1'b1, "R8 ext active-high asserted", {7'b0, irq_ext_o}, 8'h01);
    irq_pol_i = 1'b0; #1;
    check(irq_ext_o === 1'b0, "R8 ext active-low asserted", {7'b0, irq_ext_o}, 8'h00);
    do_read(v);
    check(v === 8'hC0, "R4 read value", v, 8'hC0);
    check_irq("R6 request drops after clear", 1'b1);
    check_byte("R6 status empty", 8'h00);
  endtask

  task automatic t_held_event;
    logic [7:0] v;
    pulse(3'b011);
    tick;
    rd_i = 1'b1;
    check_byte("R1 alarm+update, periodic enabled only", 8'h30);
    evt_periodic_i = 1'b1;
    tick;
    evt_periodic_i = 1'b0;
    check_irq("R7 held event gives no request in read", 1'b1);
    tick;
    check_byte("R5 byte unchanged by held event", 8'h30);
    rd_i = 1'b0;
    tick;
    check_irq("R7 held event posted at read end", 1'b0);
    tick;
    check_byte("R6 returned bits cleared, R7 periodic kept", 8'hC0);
    do_read(v);
    check_irq("R6 idle after second read", 1'b1);
  endtask

  task automatic t_coincide;
    logic [7:0] v;
    write_en(3'b010);
    pulse(3'b010);
    check_irq("R2 alarm enabled", 1'b0);
    tick;
    rd_i = 1'b1;
    check_byte("R4 alarm with summary", 8'hA0);
    evt_alarm_i = 1'b1;
    tick;
    evt_alarm_i = 1'b0;
    tick;
    rd_i = 1'b0;
    tick;
    check_irq("R7 same-flag event survives clear", 1'b0);
    tick;
    check_byte("R7 alarm still set", 8'hA0);
    do_read(v);
    check_byte("R6 alarm cleared", 8'h00);
    check_irq("R6 request released", 1'b1);
  endtask

  task automatic t_each_source;
    logic [7:0] v;
    for (int i = 0; i < 3; i++) begin
      logic [2:0] m;
      m = 3'b001 << i;
      write_en(~m);
      pulse(m);
      check_irq("R2 other sources enabled only", 1'b1);
      write_en(m);
      check_irq("R2 own source enabled", 1'b0);
      tick;
      check_byte("R1 single flag position", status(1'b1, m[2], m[1], m[0]));
      do_read(v);
      check_irq("R6 released per source", 1'b1);
    end
  endtask

  initial begin
    #1_600_000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #10;
    rst_n = 1'b1;
    t_reset;
    t_flag_masked;
    t_late_enable;
    t_held_event;
    t_coincide;
    t_each_source;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule